// File: doc/BRIEF.md
# Freezable Performance Counter Bank

This block holds a bank of event counters behind a simple 32-bit register interface. Slot 0 is a wide counter that advances on every clock cycle. Every other slot is a 32-bit counter that advances on each cycle its selected event strobe is high, where a 7-bit code chosen per slot selects that strobe. The strobes arrive from outside: one vector of reference strobes that all slots share, and a small group of strobes private to each slot.

Counting is gated at two levels. A global freeze bit stops every slot at once. A freeze bit in each slot stops only that slot. The global bit wins over the local ones. Software arms overflow detection with two global enables and a per-slot enable. When an armed slot advances and its top bit goes from 0 to 1, the hardware sets the global freeze bit at the same clock edge, so every slot keeps the value it had at the moment of overflow. The hardware also raises a level interrupt. The interrupt stays high until software has cleared both the global freeze and the top bit of every armed slot.

Reads are combinational from the address. Writes complete at the next rising clock edge.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every count reads 0, every slot control register reads 0, the global control register reads 0x8000_0000 (frozen), `irq` is 0, and no slot advances while the bank stays frozen.
- R2: Slot 0 is 64 bits wide. It advances by one on every cycle in which it is not frozen, whatever its event code. The carry passes from the low word (offset 0x58) into the high word (offset 0x5C).
- R3: Slots 1 to 10 advance by one on each unfrozen cycle in which the selected strobe is high. Codes 0 and 12..63 select `ref_evt[code]`. Codes 64..71 select bit (code-64) of the slot's own 8-bit group, `spec_evt[(n-1)*8 +: 8]`. Codes 1..11 and 72..127 select nothing, so the slot never counts.
- R4: A slot holds its count while its local freeze bit (bit 31 of its control register) is 1, or while the global freeze bit (bit 31 of 0x40) is 1. A clear local bit does not override a set global bit.
- R5: An armed slot is one whose condition enable (bit 26) is 1 while the global interrupt enable (bit 30) and the global freeze-on-condition enable (bit 29) are both 1. When an armed slot advances and its MSB goes from 0 to 1, the global freeze bit is set at that same edge and `irq` is high after it. All slots then hold their values, so the overflowing slot reads exactly its MSB value (0x8000_0000 for a 32-bit slot).
- R6: If any one of the three enables is 0, an MSB rising edge raises no interrupt and causes no freeze, and the slot keeps counting past it.
- R7: `irq` is a level output. It stays 1 while the global freeze bit is 1, or while any slot with condition enable set has its MSB set. It falls one cycle after both of these conditions are gone.
- R8: Count registers are writable. A write at the same edge as an advance takes precedence, so the write value is stored unchanged.
- R9: Every offset outside the map reads 0, and writes to those offsets have no effect. This includes the reserved word at 0x54+0x10*n. Bits of the control registers that have no function read 0.
- R10: The map places the global control register at 0x40. Slot n has its control register at 0x50+0x10*n and its count at 0x58+0x10*n. In a slot control register, bit 31 is the freeze bit, bit 26 is the condition enable and bits 22:16 hold the event code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe; the write takes effect at the next rising edge |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ref_evt | input | 64 | Reference event strobes shared by slots 1..10 |
| spec_evt | input | 80 | Private strobes, 8 for each of slots 1..10 |
| irq | output | 1 | Overflow interrupt, level |

## Verification
An advance caused by a strobe, or a write, becomes visible in the count one edge later. A gate window opened by a write to the global register at edge A and closed by a freeze write at edge A+K+1 therefore adds exactly K+1 counts for a strobe that is held high throughout. The bench keeps every strobe constant across such windows and reads only after the freeze write has landed. The freeze bit and `irq` change at the same edge as the increment that sets the MSB, so the bench samples `irq` at the falling edges just before and just after that increment. The release of `irq` is due one edge after the last cause is cleared, and the bench checks both sides of that edge.

// File: rtl/pcb_pkg.sv
// pcb_pkg: register map constants, bit positions and the slot control type
// shared by the performance counter bank modules.
package pcb_pkg;
    localparam int REG_W       = 32;
    localparam int CODE_W      = 7;
    localparam int REF_W       = 2 ** (CODE_W - 1);

    localparam int GC_OFS      = 'h40;
    localparam int BANK_BASE   = 'h50;
    localparam int BANK_STRIDE = 'h10;
    localparam int LCA_SUB     = 0;
    localparam int CNT_SUB     = 8;
    localparam int CNT_HI_SUB  = 12;

    localparam int GFRZ_BIT    = 31;
    localparam int GIE_BIT     = 30;
    localparam int GCFE_BIT    = 29;
    localparam int LFRZ_BIT    = 31;
    localparam int LCE_BIT     = 26;
    localparam int CODE_LSB    = 16;

    typedef struct packed {
        logic              frz;
        logic              ce;
        logic [CODE_W-1:0] code;
    } slot_ctl_t;
endpackage

// File: rtl/pcb_evt_sel.sv
// pcb_evt_sel: turns a slot's event code into a single strobe.
// Codes below 2**(CODE_W-1) index the shared reference vector, except
// codes 1..GAP_LAST, which select nothing. Codes at or above that index the
// slot's private group; codes past the end of the group select nothing.
// Assumes SPEC_W >= 2 and SPEC_W <= 2**(CODE_W-1).
module pcb_evt_sel #(
    parameter int CODE_W   = 7,
    parameter int SPEC_W   = 8,
    parameter int GAP_LAST = 11
) (
    input  logic [CODE_W-1:0]           code,
    input  logic [2**(CODE_W-1)-1:0]    ref_evt,
    input  logic [SPEC_W-1:0]           spec_evt,
    output logic                        hit
);
    localparam int SEL_W = $clog2(SPEC_W);

    logic [CODE_W-2:0] low;
    assign low = code[CODE_W-2:0];

    // choose the strobe named by the code
    always_comb begin
        if (code[CODE_W-1]) begin
            hit = (int'(low) < SPEC_W) ? spec_evt[low[SEL_W-1:0]] : 1'b0;
        end else if (int'(low) >= 1 && int'(low) <= GAP_LAST) begin
            hit = 1'b0;
        end else begin
            hit = ref_evt[low];
        end
    end
endmodule

// File: rtl/pcb_counter.sv
// pcb_counter: one W-bit count register, writable per 32-bit word.
// It advances by one when adv is high. A word write overrides the advance
// for that word. ovf flags an advance that takes the MSB from 0 to 1 while
// the top word is not being written. Assumes W is a multiple of 32.
module pcb_counter #(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [W/32-1:0]     wr_word,
    input  logic [31:0]         wdata,
    output logic [W-1:0]        cnt,
    output logic                ovf
);
    localparam int NW = W / 32;

    logic [W-1:0] inc;
    logic [W-1:0] nxt;

    // next value: advance, then apply any word writes on top
    always_comb begin
        inc = cnt + W'(1);
        nxt = adv ? inc : cnt;
        for (int w = 0; w < NW; w++) begin
            if (wr_word[w]) nxt[w*32 +: 32] = wdata;
        end
    end

    assign ovf = adv & ~wr_word[NW-1] & ~cnt[W-1] & inc[W-1];

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    // R4: a slot that neither advances nor is written keeps its value
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && wr_word == '0) |=> $stable(cnt));

    // R3: an advance without a write moves the count by exactly one
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wr_word == '0) |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/pcb_global_ctl.sv
// pcb_global_ctl: global freeze, interrupt enable and freeze-on-condition
// enable, plus the level interrupt. An armed overflow sets the freeze bit
// at the same edge as the increment, and it wins over a software write.
// The interrupt clears once freeze is off and no armed slot has its MSB set.
module pcb_global_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wd_frz,
    input  logic wd_ie,
    input  logic wd_cfe,
    input  logic ovf_ce_any,
    input  logic msb_ce_any,
    output logic frz,
    output logic ie,
    output logic cfe,
    output logic irq
);
    logic trig;
    assign trig = ie & cfe & ovf_ce_any;

    // global control bits; an overflow forces freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz <= 1'b1;
            ie  <= 1'b0;
            cfe <= 1'b0;
        end else begin
            if (wr) begin
                ie  <= wd_ie;
                cfe <= wd_cfe;
            end
            if (trig)    frz <= 1'b1;
            else if (wr) frz <= wd_frz;
        end
    end

    // interrupt level: set on overflow, released once both causes are gone
    always_ff @(posedge clk) begin
        if (!rst_n)                      irq <= 1'b0;
        else if (trig)                   irq <= 1'b1;
        else if (!frz && !msb_ce_any)    irq <= 1'b0;
    end

    // R5: an armed overflow freezes the bank and raises the interrupt
    assert_trig_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (frz && irq));

    // R7: the interrupt holds while either cause remains
    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (frz || msb_ce_any)) |=> irq);

    // R6: the interrupt only rises when both global enables were set
    assert_irq_needs_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ie && cfe));
endmodule

// File: rtl/perf_counter_bank.sv
// perf_counter_bank: slot 0 counts cycles (64 bits). Slots 1..NUM_CTRS-1
// count selected event strobes (32 bits). The bank has a register interface
// with combinational reads and writes taken at the clock edge. Assumes
// EVT_CNT_W == 32, CYC_CNT_W == 64 and that the map fits in ADDR_W bits.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CTRS  = 11,
    parameter int EVT_CNT_W = 32,
    parameter int CYC_CNT_W = 64,
    parameter int SPEC_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int GAP_LAST  = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [REF_W-1:0]              ref_evt,
    input  logic [(NUM_CTRS-1)*SPEC_W-1:0] spec_evt,
    output logic                          irq
);
    localparam int CYC_NW = CYC_CNT_W / REG_W;

    function automatic logic [ADDR_W-1:0] slot_addr(input int n, input int sub);
        return ADDR_W'(BANK_BASE + n * BANK_STRIDE + sub);
    endfunction

    slot_ctl_t             lca_q [NUM_CTRS];
    logic [NUM_CTRS-1:0]   lca_hit, cnt_lo_hit;
    logic [NUM_CTRS-1:0]   adv, evt_hit, ovf, msb, ce_vec;
    logic [REG_W-1:0]      cnt_lo [NUM_CTRS];
    logic [REG_W-1:0]      cnt_hi0;
    logic                  cnt0_hi_hit, gc_hit;
    logic                  g_frz, g_ie, g_cfe;

    assign gc_hit      = (reg_addr == ADDR_W'(GC_OFS));
    assign cnt0_hi_hit = (reg_addr == slot_addr(0, CNT_HI_SUB));

    // slot control registers
    always_ff @(posedge clk) begin
        for (int n = 0; n < NUM_CTRS; n++) begin
            if (!rst_n) begin
                lca_q[n] <= '0;
            end else if (reg_wr && lca_hit[n]) begin
                lca_q[n].frz  <= reg_wdata[LFRZ_BIT];
                lca_q[n].ce   <= reg_wdata[LCE_BIT];
                lca_q[n].code <= reg_wdata[CODE_LSB +: CODE_W];
            end
        end
    end

    for (genvar n = 0; n < NUM_CTRS; n++) begin : g_slot
        assign lca_hit[n]    = (reg_addr == slot_addr(n, LCA_SUB));
        assign cnt_lo_hit[n] = (reg_addr == slot_addr(n, CNT_SUB));
        assign adv[n]        = ~g_frz & ~lca_q[n].frz & evt_hit[n];
        assign ce_vec[n]     = lca_q[n].ce;

        if (n == 0) begin : g_cyc
            logic [CYC_CNT_W-1:0] cval;
            logic [CYC_NW-1:0]    wsel;
            assign evt_hit[n] = 1'b1;
            assign wsel       = {reg_wr & cnt0_hi_hit, reg_wr & cnt_lo_hit[n]};
            pcb_counter #(.W(CYC_CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv[n]),
                .wr_word (wsel),
                .wdata   (reg_wdata),
                .cnt     (cval),
                .ovf     (ovf[n])
            );
            assign cnt_lo[n] = cval[REG_W-1:0];
            assign cnt_hi0   = cval[CYC_CNT_W-1:REG_W];
            assign msb[n]    = cval[CYC_CNT_W-1];
        end else begin : g_evt
            logic [EVT_CNT_W-1:0] cval;
            pcb_evt_sel #(.CODE_W(CODE_W), .SPEC_W(SPEC_W), .GAP_LAST(GAP_LAST)) u_sel (
                .code     (lca_q[n].code),
                .ref_evt  (ref_evt),
                .spec_evt (spec_evt[(n-1)*SPEC_W +: SPEC_W]),
                .hit      (evt_hit[n])
            );
            pcb_counter #(.W(EVT_CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv[n]),
                .wr_word (reg_wr & cnt_lo_hit[n]),
                .wdata   (reg_wdata),
                .cnt     (cval),
                .ovf     (ovf[n])
            );
            assign cnt_lo[n] = cval;
            assign msb[n]    = cval[EVT_CNT_W-1];
        end
    end

    pcb_global_ctl u_gctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr & gc_hit),
        .wd_frz     (reg_wdata[GFRZ_BIT]),
        .wd_ie      (reg_wdata[GIE_BIT]),
        .wd_cfe     (reg_wdata[GCFE_BIT]),
        .ovf_ce_any (|(ovf & ce_vec)),
        .msb_ce_any (|(msb & ce_vec)),
        .frz        (g_frz),
        .ie         (g_ie),
        .cfe        (g_cfe),
        .irq        (irq)
    );

    // read mux: unmapped offsets and spare bits return zero
    always_comb begin
        reg_rdata = '0;
        if (gc_hit) begin
            reg_rdata[GFRZ_BIT] = g_frz;
            reg_rdata[GIE_BIT]  = g_ie;
            reg_rdata[GCFE_BIT] = g_cfe;
        end
        if (cnt0_hi_hit) reg_rdata = cnt_hi0;
        for (int n = 0; n < NUM_CTRS; n++) begin
            if (lca_hit[n]) begin
                reg_rdata[LFRZ_BIT]              = lca_q[n].frz;
                reg_rdata[LCE_BIT]               = lca_q[n].ce;
                reg_rdata[CODE_LSB +: CODE_W]    = lca_q[n].code;
            end
            if (cnt_lo_hit[n]) reg_rdata = cnt_lo[n];
        end
    end

    // R4: global freeze holds the cycle slot when software is not writing
    assert_global_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (g_frz && !reg_wr) |=> ($stable(cnt_lo[0]) && $stable(cnt_hi0)));
endmodule

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [63:0] ref_evt;
    logic [79:0] spec_evt;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    localparam logic [31:0] FRZ = 32'h8000_0000;
    localparam logic [63:0] REF_PAT  = 64'hF0E1_D2C3_B4A5_9687;
    localparam logic [79:0] SPEC_PAT = 80'hC39A_3C5F_1E2D_4B87_66A5;

    always #2.5 clk = ~clk;

    perf_counter_bank i_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_evt(ref_evt),
        .spec_evt(spec_evt), .irq(irq)
    );

    function automatic int lca(input int n); return 'h50 + 16 * n; endfunction
    function automatic int cnt(input int n); return 'h58 + 16 * n; endfunction

    function automatic bit exp_hit(input int code, input int n,
                                   input logic [63:0] rv, input logic [79:0] sv);
        if (code >= 64) return (code - 64 < 8) ? sv[(n-1)*8 + code - 64] : 1'b0;
        if (code >= 1 && code <= 11) return 1'b0;
        return rv[code];
    endfunction

    function automatic bit mapped(input int a);
        if (a == 'h40 || a == 'h5C) return 1'b1;
        for (int n = 0; n < 11; n++)
            if (a == lca(n) || a == cnt(n)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        if (a == 'h40) return FRZ;
        if (a == 'h5C) return 32'h0000_ABCD;
        for (int n = 0; n < 11; n++) begin
            if (a == lca(n)) return 32'h847F_0000;
            if (a == cnt(n)) return 32'h1000 + 32'(n) * 32'h111;
        end
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 8'(a);
        #1 v = reg_rdata;
        @(negedge clk);
    endtask

    // gate open at edge A, closed at edge A+k+1: k+1 counting edges
    task automatic win(input logic [31:0] run, input int k);
        wr('h40, run);
        repeat (k) @(negedge clk);
        wr('h40, FRZ);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ref_evt = '1; spec_evt = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state, bank frozen, strobes all high
        rd('h40, v); chk("R1 global reset", v, FRZ);
        chk("R1 irq reset", irq, 0);
        for (int n = 0; n < 11; n++) begin
            rd(lca(n), v); chk("R1 slot ctl reset", v, 0);
            rd(cnt(n), v); chk("R1 count reset", v, 0);
        end
        rd('h5C, v); chk("R1 cycle hi reset", v, 0);

        // R2: cycle slot counts every unfrozen cycle, event code ignored
        wr(lca(0), 32'h007F_0000);
        win(0, 7);
        rd(cnt(0), v); chk("R2 cycle count", v, 8);
        wr(cnt(0), 32'hFFFF_FFFF); wr('h5C, 5);
        win(0, 1);
        rd(cnt(0), v); rd('h5C, v2);
        chk("R2 carry into high word", {v2, v}, 64'h6_0000_0001);

        // R4: local freeze holds slot 2 while slot 1 counts; global overrides
        wr(lca(1), 0); wr(cnt(1), 0);
        wr(lca(2), FRZ); wr(cnt(2), 0);
        win(0, 4);
        rd(cnt(1), v); chk("R4 unfrozen neighbour", v, 5);
        rd(cnt(2), v); chk("R4 local freeze", v, 0);
        wr(lca(2), 0);
        repeat (10) @(negedge clk);
        rd(cnt(2), v); chk("R4 global over local", v, 0);

        // R3: every code on every event slot
        ref_evt = REF_PAT; spec_evt = SPEC_PAT;
        for (int n = 1; n < 11; n++) begin
            for (int code = 0; code < 128; code++) begin
                int k;
                k = 1 + code % 3;
                wr(lca(n), 32'(code) << 16);
                wr(cnt(n), 0);
                win(0, k);
                rd(cnt(n), v);
                chk($sformatf("R3 slot%0d code%0d", n, code), v,
                    exp_hit(code, n, REF_PAT, SPEC_PAT) ? 32'(k + 1) : 32'h0);
            end
        end
        ref_evt = '1; spec_evt = '1;

        // R10: control field layout and read-back of spare bits as zero
        wr(lca(5), 32'hFFFF_FFFF);
        rd(lca(5), v); chk("R10 slot ctl fields", v, 32'h847F_0000);
        wr(lca(5), 32'h0040_0000);

        // R5: armed overflow on slot 3 freezes everything and raises irq
        wr(lca(3), 32'h0400_0000); wr(cnt(3), 32'h7FFF_FFFD);
        wr(lca(4), 0); wr(cnt(4), 0);
        wr(cnt(0), 0); wr('h5C, 0);
        wr('h40, 32'h6000_0000);           // edge A
        @(negedge clk);                    // after A+1
        chk("R5 no irq before MSB", irq, 0);
        @(negedge clk);                    // after A+2
        chk("R5 no irq before MSB", irq, 0);
        @(negedge clk);                    // after A+3: MSB set
        chk("R5 irq on MSB rise", irq, 1);
        repeat (5) @(negedge clk);
        rd('h40, v); chk("R5 freeze set by hardware", v, 32'hE000_0000);
        rd(cnt(3), v); chk("R5 overflow slot holds", v, 32'h8000_0000);
        rd(cnt(4), v); chk("R5 other slot holds", v, 3);
        rd(cnt(0), v); chk("R5 cycle slot holds", v, 3);

        // R7: clear MSB first, irq stays while frozen, drops after unfreeze
        wr(cnt(3), 0);
        repeat (3) @(negedge clk);
        chk("R7 irq held by freeze", irq, 1);
        wr('h40, 32'h6000_0000);           // edge W
        chk("R7 irq one more cycle", irq, 1);
        @(negedge clk);
        chk("R7 irq released", irq, 0);
        wr('h40, FRZ);

        // R7: freeze cleared but MSB still set keeps irq high
        wr(cnt(3), 32'h7FFF_FFFF);
        wr('h40, 32'h6000_0000);
        @(negedge clk);
        chk("R7 irq set again", irq, 1);
        wr('h40, 32'h6000_0000);
        repeat (3) @(negedge clk);
        chk("R7 irq held by MSB", irq, 1);
        wr(cnt(3), 0);
        wr('h40, FRZ);
        wr('h40, 32'h6000_0000);
        @(negedge clk);
        chk("R7 irq released after both", irq, 0);
        wr('h40, FRZ);

        // R6: each missing enable suppresses the interrupt and freeze
        wr(cnt(3), 32'h7FFF_FFFE);
        win(32'h2000_0000, 4);
        rd(cnt(3), v); chk("R6 no int enable counts on", v, 32'h8000_0003);
        chk("R6 no int enable irq", irq, 0);
        wr(cnt(3), 32'h7FFF_FFFE);
        win(32'h4000_0000, 4);
        rd(cnt(3), v); chk("R6 no cond enable counts on", v, 32'h8000_0003);
        chk("R6 no cond enable irq", irq, 0);
        wr(lca(3), 0); wr(cnt(3), 32'h7FFF_FFFE);
        win(32'h6000_0000, 4);
        rd(cnt(3), v); chk("R6 slot not armed counts on", v, 32'h8000_0003);
        chk("R6 slot not armed irq", irq, 0);

        // R2/R5: 64-bit cycle slot overflow
        wr(lca(0), 32'h0400_0000);
        wr('h5C, 32'h7FFF_FFFF); wr(cnt(0), 32'hFFFF_FFFE);
        wr('h40, 32'h6000_0000);
        repeat (4) @(negedge clk);
        chk("R5 cycle slot irq", irq, 1);
        rd('h5C, v); rd(cnt(0), v2);
        chk("R2 cycle slot at MSB", {v, v2}, 64'h8000_0000_0000_0000);
        wr('h5C, 0);
        wr('h40, 0);
        @(negedge clk);
        chk("R7 cycle irq released", irq, 0);
        wr('h40, FRZ);
        wr(lca(0), 0);

        // R8: a write at the same edge as an advance wins
        wr(lca(1), 0);
        wr('h40, 0);
        wr(cnt(1), 100);
        repeat (3) @(negedge clk);
        wr('h40, FRZ);
        rd(cnt(1), v); chk("R8 write over advance", v, 104);
        wr('h5C, 32'h1234); wr(cnt(0), 32'h5678);
        rd('h5C, v); rd(cnt(0), v2);
        chk("R8 cycle words writable", {v, v2}, 64'h1234_0000_5678);

        // R9/R10: full address sweep with garbage written to unmapped offsets
        for (int n = 0; n < 11; n++) begin
            wr(lca(n), 32'hFFFF_FFFF);
            wr(cnt(n), 32'h1000 + 32'(n) * 32'h111);
        end
        wr('h5C, 32'h0000_ABCD);
        for (int a = 0; a < 256; a++)
            if (!mapped(a)) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 256; a++) begin
            rd(a, v);
            chk($sformatf("R9 R10 offset %0h", a), v, exp_read(a));
        end
        chk("R9 irq untouched", irq, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule